// File: doc/BRIEF.md
# Inbound Memory Access Admission Gate

This block sits between the receive side of a serial packet link and the on-chip memory bus. For each received direct-access packet it decides whether the packet may send its memory bus command now. It holds a small table of in-flight commands, each described by the source ID, destination ID and priority of the packet that started it. A new packet must wait when it would overtake an ordered predecessor, or when the table is full. Doorbell packets carry no command. The block drains the commands that were outstanding when the doorbell arrived, then raises an interrupt pulse. A second doorbell that arrives while one is still pending is refused with a retry pulse.

Packets arrive on a valid/ready stream and are considered strictly in arrival order. The upstream source must hold `pkt_valid` and every packet field stable until it sees `pkt_ready` high. A blocked head packet therefore stalls everything behind it. A transfer happens in a cycle where both signals are high. An accepted ordinary packet issues its command in that same cycle on `cmd_issue`, together with the slot it took. The memory bus later returns `cpl_valid` with that slot number. The command issue, interrupt and retry outputs are single-cycle pulses with no back-pressure.

Top module: `inbound_admit`

## Requirements
- R1: An ordinary packet (`pkt_doorbell`=0) that is accepted raises `cmd_issue` in the cycle of the handshake. `cmd_slot` gives the lowest-numbered free slot, and that slot is busy from the next cycle.
- R2: At most four commands are in flight. When all four slots are busy, `pkt_ready` is low for an ordinary packet.
- R3: An ordinary packet is held (`pkt_ready`=0) while any busy slot has the same source ID and the same destination ID as the packet, with a priority greater than or equal to the packet's priority. Priority is a 2-bit value, and 3 is the highest.
- R4: A packet that differs from every busy slot in source ID, in destination ID, or by having a strictly higher priority is admitted, provided a slot is free.
- R5: `cpl_valid` with `cpl_slot` frees that slot at the clock edge that ends the cycle. A waiting packet can issue in the next cycle. A completion naming a slot that is not busy has no effect.
- R6: A doorbell is always accepted (`pkt_ready`=1) and issues no command. `irq_post` pulses for one cycle. It pulses in the cycle after the last completion of the commands that were in flight when the doorbell was accepted. If none were in flight, it pulses in the cycle after acceptance.
- R7: A doorbell arriving while an earlier doorbell is pending, including the cycle in which that earlier one posts its interrupt, raises `retry` in the same cycle. It is consumed and discarded, and it does not change the pending doorbell.
- R8: Commands admitted after a doorbell is accepted do not delay that doorbell's interrupt.
- R9: After reset all slots are free and no doorbell is pending. With no input activity, `pkt_ready`=1 and `cmd_issue`, `irq_post` and `retry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Received packet present |
| pkt_ready | output | 1 | Packet accepted this cycle when valid |
| pkt_src | input | 16 | Source ID of the packet |
| pkt_dst | input | 16 | Destination ID of the packet |
| pkt_prio | input | 2 | Packet priority, 3 highest |
| pkt_doorbell | input | 1 | Packet is a doorbell |
| cmd_issue | output | 1 | Memory bus command issued this cycle |
| cmd_slot | output | 2 | Slot taken by the issued command |
| cpl_valid | input | 1 | Memory bus command completed |
| cpl_slot | input | 2 | Slot of the completed command |
| irq_post | output | 1 | Doorbell interrupt pulse |
| retry | output | 1 | Doorbell refused with a retry |

## Verification
The hardest situation to reach from the ports is a doorbell draining a full table while new commands refill freed slots. A further doorbell must also arrive in exactly the cycle its predecessor posts. The directed part of the stimulus fills all four slots with packets whose IDs and priorities are picked to pass or fail the ordering check one field at a time. It then lands doorbells and a replacement command at chosen points between completions. A long constrained-random phase then runs from a two-value ID space, so conflicts are frequent. Completions are aimed at slots that are busy in the reference model, with occasional stray completions. Every output is compared against the model on every clock.

// File: rtl/admit_pkg.sv
package admit_pkg;
  parameter int unsigned ADM_ID_W   = 16;
  parameter int unsigned ADM_PRIO_W = 2;

  typedef struct packed {
    logic [ADM_ID_W-1:0]   src;
    logic [ADM_ID_W-1:0]   dst;
    logic [ADM_PRIO_W-1:0] prio;
  } adm_entry_t;
endpackage

// File: rtl/admit_slot_table.sv
module admit_slot_table
  import admit_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  adm_entry_t        alloc_entry,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [N_SLOTS-1:0] busy,
  output adm_entry_t        entries [N_SLOTS],
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              has_free
);
  // lowest free slot
  always_comb begin
    alloc_slot = '0;
    has_free   = 1'b0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_slot = SLOT_W'(i);
        has_free   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic take_here;
    logic drop_here;
    assign take_here = alloc_en && (alloc_slot == SLOT_W'(g));
    assign drop_here = free_en && (free_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[g]    <= 1'b0;
        entries[g] <= '0;
      end else if (take_here) begin
        busy[g]    <= 1'b1;
        entries[g] <= alloc_entry;
      end else if (drop_here) begin
        busy[g]    <= 1'b0;
      end
    end
  end

  // R1
  slot_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy[$past(alloc_slot)]);

  // R5
  slot_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_en && !alloc_en && busy[free_slot]) |=> !busy[$past(free_slot)]);
endmodule

// File: rtl/admit_order_check.sv
module admit_order_check
  import admit_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SLOTS-1:0]    busy,
  input  adm_entry_t            entries [N_SLOTS],
  input  logic [ADM_ID_W-1:0]   cand_src,
  input  logic [ADM_ID_W-1:0]   cand_dst,
  input  logic [ADM_PRIO_W-1:0] cand_prio,
  output logic                  conflict
);
  logic [N_SLOTS-1:0] hit;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign hit[g] = busy[g]
                 && (entries[g].src == cand_src)
                 && (entries[g].dst == cand_dst)
                 && (entries[g].prio >= cand_prio);
  end

  assign conflict = |hit;

  // R3
  conflict_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (busy != '0));
endmodule

// File: rtl/admit_doorbell_drain.sv
module admit_doorbell_drain #(
  parameter int unsigned N_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               db_take,
  input  logic [N_SLOTS-1:0] busy,
  input  logic               free_en,
  input  logic [SLOT_W-1:0]  free_slot,
  output logic               pending,
  output logic               irq
);
  logic [N_SLOTS-1:0] wait_mask;
  logic [N_SLOTS-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (free_en) clr_vec[free_slot] = 1'b1;
  end

  assign irq = pending && (wait_mask == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      wait_mask <= '0;
    end else if (db_take) begin
      pending   <= 1'b1;
      wait_mask <= busy & ~clr_vec;
    end else if (irq) begin
      pending   <= 1'b0;
      wait_mask <= '0;
    end else if (pending) begin
      wait_mask <= wait_mask & ~clr_vec;
    end
  end

  // R6
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  take_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    db_take |-> !pending);

  // R8
  mask_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !irq && !db_take) |=> ((wait_mask & ~$past(wait_mask)) == '0));
endmodule

// File: rtl/inbound_admit.sv
module inbound_admit
  import admit_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  output logic                  pkt_ready,
  input  logic [ADM_ID_W-1:0]   pkt_src,
  input  logic [ADM_ID_W-1:0]   pkt_dst,
  input  logic [ADM_PRIO_W-1:0] pkt_prio,
  input  logic                  pkt_doorbell,
  output logic                  cmd_issue,
  output logic [SLOT_W-1:0]     cmd_slot,
  input  logic                  cpl_valid,
  input  logic [SLOT_W-1:0]     cpl_slot,
  output logic                  irq_post,
  output logic                  retry
);
  logic [N_SLOTS-1:0] busy;
  adm_entry_t         entries [N_SLOTS];
  adm_entry_t         new_entry;
  logic [SLOT_W-1:0]  alloc_slot;
  logic               has_free;
  logic               conflict;
  logic               db_pending;
  logic               db_take;
  logic               admit_ok;

  assign new_entry = '{src: pkt_src, dst: pkt_dst, prio: pkt_prio};

  admit_slot_table #(.N_SLOTS(N_SLOTS)) table_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (cmd_issue),
    .alloc_entry (new_entry),
    .free_en     (cpl_valid),
    .free_slot   (cpl_slot),
    .busy        (busy),
    .entries     (entries),
    .alloc_slot  (alloc_slot),
    .has_free    (has_free)
  );

  admit_order_check #(.N_SLOTS(N_SLOTS)) order_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .entries   (entries),
    .cand_src  (pkt_src),
    .cand_dst  (pkt_dst),
    .cand_prio (pkt_prio),
    .conflict  (conflict)
  );

  admit_doorbell_drain #(.N_SLOTS(N_SLOTS)) drain_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_take   (db_take),
    .busy      (busy),
    .free_en   (cpl_valid),
    .free_slot (cpl_slot),
    .pending   (db_pending),
    .irq       (irq_post)
  );

  assign admit_ok  = has_free && !conflict;
  assign pkt_ready = pkt_doorbell ? 1'b1 : admit_ok;
  assign cmd_issue = pkt_valid && !pkt_doorbell && admit_ok;
  assign cmd_slot  = alloc_slot;
  assign db_take   = pkt_valid && pkt_doorbell && !db_pending;
  assign retry     = pkt_valid && pkt_doorbell && db_pending;

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_doorbell && ($countones(busy) == N_SLOTS)) |-> !pkt_ready);

  // R3
  conflict_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && conflict) |-> !cmd_issue);

  // R6
  doorbell_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_doorbell) |-> (pkt_ready && !cmd_issue));

  // R7
  retry_keeps_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retry && !irq_post) |=> db_pending);
endmodule

// File: tb/inbound_admit_tb_top.sv
module inbound_admit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        pkt_valid = 0, pkt_doorbell = 0, cpl_valid = 0;
  logic [15:0] pkt_src = 0, pkt_dst = 0;
  logic [1:0]  pkt_prio = 0, cpl_slot = 0;
  logic        pkt_ready, cmd_issue, irq_post, retry;
  logic [1:0]  cmd_slot;

  inbound_admit dut_i (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_src(pkt_src), .pkt_dst(pkt_dst), .pkt_prio(pkt_prio),
    .pkt_doorbell(pkt_doorbell),
    .cmd_issue(cmd_issue), .cmd_slot(cmd_slot),
    .cpl_valid(cpl_valid), .cpl_slot(cpl_slot),
    .irq_post(irq_post), .retry(retry)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  bit          mb [4];
  logic [15:0] ms [4], md [4];
  int          mp [4];
  bit          mpend;
  bit [3:0]    mmask;
  // next-state
  bit          nb [4];
  logic [15:0] ns_ [4], nd [4];
  int          np [4];
  bit          npend;
  bit [3:0]    nmask;
  bit          acc_last;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n) begin
      int  fr;
      bit  cf, e_rdy, e_iss, e_ret, e_irq;
      bit [3:0] clr;
      fr = -1;
      for (int i = 3; i >= 0; i--) if (!mb[i]) fr = i;
      cf = 0;
      for (int i = 0; i < 4; i++)
        if (mb[i] && ms[i] == pkt_src && md[i] == pkt_dst && mp[i] >= int'(pkt_prio)) cf = 1;
      e_rdy = pkt_doorbell ? 1'b1 : (fr >= 0 && !cf);
      e_iss = pkt_valid && !pkt_doorbell && fr >= 0 && !cf;
      e_ret = pkt_valid && pkt_doorbell && mpend;
      e_irq = mpend && (mmask == 0);
      chk(pkt_ready == e_rdy, "R2/R3 pkt_ready", pkt_ready, e_rdy);
      chk(cmd_issue == e_iss, "R1/R4 cmd_issue", cmd_issue, e_iss);
      if (e_iss) chk(int'(cmd_slot) == fr, "R1 cmd_slot", cmd_slot, fr);
      chk(retry == e_ret, "R7 retry", retry, e_ret);
      chk(irq_post == e_irq, "R6 irq_post", irq_post, e_irq);
      acc_last = pkt_valid && e_rdy;
      // next state
      clr = 0;
      if (cpl_valid) clr[cpl_slot] = 1'b1;
      for (int i = 0; i < 4; i++) begin
        nb[i] = mb[i]; ns_[i] = ms[i]; nd[i] = md[i]; np[i] = mp[i];
        if (clr[i]) nb[i] = 0;
      end
      if (e_iss) begin
        nb[fr] = 1; ns_[fr] = pkt_src; nd[fr] = pkt_dst; np[fr] = int'(pkt_prio);
      end
      npend = mpend; nmask = mmask;
      if (pkt_valid && pkt_doorbell && !mpend) begin
        npend = 1;
        nmask = 0;
        for (int i = 0; i < 4; i++) nmask[i] = mb[i] && !clr[i];
      end else if (e_irq) begin
        npend = 0; nmask = 0;
      end else if (mpend) begin
        nmask = mmask & ~clr;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin mb[i] = 0; ms[i] = 0; md[i] = 0; mp[i] = 0; end
      mpend = 0; mmask = 0; acc_last = 1;
    end else begin
      for (int i = 0; i < 4; i++) begin mb[i] = nb[i]; ms[i] = ns_[i]; md[i] = nd[i]; mp[i] = np[i]; end
      mpend = npend; mmask = nmask;
    end
  end

  task automatic step(input bit v, input int s, input int d, input int p, input bit db,
                      input bit cv, input int cs);
    @(posedge clk); #1;
    pkt_valid = v; pkt_src = 16'(s); pkt_dst = 16'(d); pkt_prio = 2'(p);
    pkt_doorbell = db; cpl_valid = cv; cpl_slot = 2'(cs);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(pkt_ready == 1, "R9 ready after reset", pkt_ready, 1);
    chk(cmd_issue == 0 && irq_post == 0 && retry == 0, "R9 quiet after reset",
        {cmd_issue, irq_post, retry}, 0);

    step(1, 1, 2, 1, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 0, "R1 first issue slot0", cmd_slot, 0);
    step(1, 1, 2, 1, 0, 0, 0);
    chk(!pkt_ready, "R3 equal priority held", pkt_ready, 0);
    step(1, 1, 2, 0, 0, 0, 0);
    chk(!pkt_ready, "R3 lower priority held", pkt_ready, 0);
    step(1, 1, 2, 2, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 1, "R4 higher priority issues", cmd_slot, 1);
    step(1, 1, 3, 3, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 2, "R4 dst differs issues", cmd_slot, 2);
    step(1, 5, 2, 3, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 3, "R4 src differs issues", cmd_slot, 3);
    step(1, 9, 9, 0, 0, 0, 0);
    chk(!pkt_ready, "R2 full table holds", pkt_ready, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(pkt_ready && !retry && !cmd_issue, "R6 doorbell accepted", pkt_ready, 1);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(retry, "R7 second doorbell retried", retry, 1);
    step(1, 9, 9, 0, 0, 1, 1);
    chk(!pkt_ready, "R5 freed slot not yet usable", pkt_ready, 0);
    step(1, 9, 9, 0, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 1, "R5 freed slot reused", cmd_slot, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 0, 1, 3);
    chk(!irq_post, "R6 no irq before drain", irq_post, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(irq_post, "R8 irq despite later command", irq_post, 1);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(!retry && !irq_post, "R6 new doorbell after post", retry, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    chk(!irq_post, "R6 waits for slot1", irq_post, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(irq_post, "R6 irq after slot1", irq_post, 1);
    step(1, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(irq_post && retry, "R7 retry in posting cycle", retry, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk(!irq_post, "R7 retried doorbell discarded", irq_post, 0);
    step(1, 1, 2, 1, 0, 0, 0);
    chk(cmd_issue && cmd_slot == 0, "R1 issue into empty", cmd_slot, 0);
    step(0, 0, 0, 0, 0, 1, 3);
    step(1, 1, 2, 1, 0, 0, 0);
    chk(!pkt_ready, "R5 idle completion ignored", pkt_ready, 0);
    step(0, 0, 0, 0, 0, 1, 0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      bit keep;
      keep = pkt_valid && !acc_last;
      @(posedge clk); #1;
      if (!keep) begin
        pkt_valid    = ($urandom_range(0, 3) != 0);
        pkt_src      = 16'($urandom_range(0, 1));
        pkt_dst      = 16'($urandom_range(0, 1));
        pkt_prio     = 2'($urandom_range(0, 3));
        pkt_doorbell = ($urandom_range(0, 9) == 0);
      end
      begin
        int s;
        s = $urandom_range(0, 3);
        cpl_slot  = 2'(s);
        cpl_valid = (mb[s] && $urandom_range(0, 2) == 0) || ($urandom_range(0, 15) == 0);
      end
    end
    @(posedge clk); #1;
    pkt_valid = 0; cpl_valid = 0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule